// File: doc/BRIEF.md
# Multi-Master Arbitrating I2C Byte Transmitter

This block is the master-side transmit engine of an I2C port that shares its bus with other masters. It drives SDA and SCL only through open-drain pull-down enables and reads both lines back through two-flop synchronisers. Each time it releases SDA to send a one while SCL is high, it compares the sampled line with the released level. The sample is taken a fixed number of settling cycles after SCL is released, so a slow-rising line is not taken for a lost bit. A mismatch means another master owns the bus. The block then aborts whatever it was doing, releases both lines, raises a sticky collision flag and returns to idle.

Software issues start, repeated start, stop and acknowledge commands as one-cycle strobes and loads bytes with a write strobe. While a sequence runs, one bit of a four-bit busy vector shows which command is active. A bus monitor keeps following start and stop conditions from any master. From them it reports whether the bus is free, and it raises a general event flag when a stop goes by. A start requested on a busy bus is refused at once as a collision and never touches the lines.

Top module: `i2c_arb_tx`

## Requirements
- R1: After reset, sda_lo, scl_lo, buf_full, coll_flag, evt_flag, start_seen, stop_seen are 0 and cmd_busy is 4'b0000.
- R2: A start strobe on a free bus sets cmd_busy[0], releases both lines, then pulls SDA low with SCL released, then pulls SCL low. cmd_busy[0] then clears and evt_flag sets, with both lines held low.
- R3: A write strobe while buf_full is 0 loads the byte and sets buf_full. From the held state the byte is sent MSB first, one bit per SCL pulse, followed by a ninth pulse with SDA released. buf_full clears at the end of that ninth pulse. Within a byte, sda_lo changes only while scl_lo is 1 in both the current and the previous cycle.
- R4: From the held state, a repeated-start strobe sets cmd_busy[1] and produces a new start condition. A stop strobe sets cmd_busy[2], drives SDA low, releases SCL, then releases SDA. An acknowledge strobe sets cmd_busy[3] and sends one bit equal to ack_val. The busy bit clears when its sequence ends; after a stop both lines are released.
- R5: A collision is raised when SDA is released by the block, SCL is sampled high, and SDA is sampled low SETTLE cycles after SCL was released. A collision sets coll_flag.
- R6: A collision during a byte stops the byte: in the next cycle sda_lo, scl_lo and buf_full are 0, and a new write is accepted.
- R7: A collision during a start, repeated-start, stop or acknowledge sequence aborts it, releases both lines, and clears cmd_busy to 4'b0000.
- R8: coll_flag stays 1 until a coll_clr pulse. If a collision and coll_clr fall in the same cycle, the flag stays 1.
- R9: A start condition is SDA falling while SCL is high; a stop condition is SDA rising while SCL is high. Each condition, from any master, sets its own status bit (start_seen, stop_seen) and clears the other. A stop condition sets evt_flag.
- R10: The bus is free when stop_seen is 1 or both status bits are 0. A start strobe on a busy bus sets coll_flag in the next cycle and leaves sda_lo and scl_lo at 0.
- R11: A byte written after a collision is sent from its MSB, whatever bit the aborted byte had reached.
- R12: evt_flag stays 1 until an evt_clr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Load wr_data into the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| start_cmd | input | 1 | Start command strobe |
| rstart_cmd | input | 1 | Repeated-start command strobe |
| stop_cmd | input | 1 | Stop command strobe |
| ack_cmd | input | 1 | Acknowledge-bit command strobe |
| ack_val | input | 1 | Bit level sent by the acknowledge command |
| coll_clr | input | 1 | Clears coll_flag |
| evt_clr | input | 1 | Clears evt_flag |
| scl_in | input | 1 | Level of the SCL line |
| sda_in | input | 1 | Level of the SDA line |
| sda_lo | output | 1 | Pull SDA low when 1 |
| scl_lo | output | 1 | Pull SCL low when 1 |
| buf_full | output | 1 | Transmit buffer holds an unsent byte |
| coll_flag | output | 1 | Sticky collision flag |
| evt_flag | output | 1 | Sticky event flag (sequence done or stop seen) |
| cmd_busy | output | 4 | Active sequence: 0 start, 1 repeated start, 2 stop, 3 acknowledge |
| start_seen | output | 1 | Last bus condition seen was a start |
| stop_seen | output | 1 | Last bus condition seen was a stop |

## Verification
Two pairs of functions can meet in the same cycle. A collision can be raised while software pulses coll_clr. The bench provokes this by pulsing start_cmd on a busy bus together with coll_clr while the flag is already set, and expects the flag to still read 1. Sequence abort and bus monitoring also overlap: when the other master pulls SDA low during our start, the monitor records its start condition while the engine aborts. The bench checks both the cleared busy vector and start_seen; a stop made later by that master must then free the bus and raise the event flag.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    typedef enum logic [3:0] {
        PH_IDLE, PH_HOLD, PH_RS_PRE, PH_STA_A, PH_STA_B,
        PH_BIT_LO, PH_BIT_HI, PH_STP_A, PH_STP_B, PH_STP_C
    } phase_e;

    localparam int CB_STA  = 0;
    localparam int CB_RSTA = 1;
    localparam int CB_STP  = 2;
    localparam int CB_ACK  = 3;
    localparam int CB_W    = 4;

    typedef struct packed {
        logic scl_m;
        logic sda_m;
        logic scl_s;
        logic sda_s;
        logic scl_p;
        logic sda_p;
        logic sta_seen;
        logic stp_seen;
    } mon_t;

endpackage

// File: rtl/i2c_arb_mon.sv
module i2c_arb_mon
    import i2c_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic stop_det,
    output logic bus_free,
    output logic start_seen,
    output logic stop_seen
);

    mon_t q, d;
    logic sta_det;

    always_comb begin
        d       = q;
        d.scl_m = scl_in;
        d.sda_m = sda_in;
        d.scl_s = q.scl_m;
        d.sda_s = q.sda_m;
        d.scl_p = q.scl_s;
        d.sda_p = q.sda_s;
        sta_det  = q.scl_s & q.scl_p & q.sda_p & ~q.sda_s;
        stop_det = q.scl_s & q.scl_p & ~q.sda_p & q.sda_s;
        if (sta_det) begin
            d.sta_seen = 1'b1;
            d.stp_seen = 1'b0;
        end
        if (stop_det) begin
            d.stp_seen = 1'b1;
            d.sta_seen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{scl_m: 1'b1, sda_m: 1'b1, scl_s: 1'b1, sda_s: 1'b1,
                           scl_p: 1'b1, sda_p: 1'b1, sta_seen: 1'b0, stp_seen: 1'b0};
        else        q <= d;
    end

    assign scl_s      = q.scl_s;
    assign sda_s      = q.sda_s;
    assign start_seen = q.sta_seen;
    assign stop_seen  = q.stp_seen;
    assign bus_free   = q.stp_seen | (~q.sta_seen & ~q.stp_seen);

    // R9
    stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (bus_free && stop_seen && !start_seen));

endmodule

// File: rtl/i2c_arb_fsm.sv
module i2c_arb_fsm
    import i2c_arb_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int SETTLE  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [7:0]      wr_data,
    input  logic            start_cmd,
    input  logic            rstart_cmd,
    input  logic            stop_cmd,
    input  logic            ack_cmd,
    input  logic            ack_val,
    input  logic            coll_clr,
    input  logic            evt_clr,
    input  logic            scl_s,
    input  logic            sda_s,
    input  logic            bus_free,
    input  logic            stop_det,
    output logic            sda_lo,
    output logic            scl_lo,
    output logic            buf_full,
    output logic            coll_flag,
    output logic            evt_flag,
    output logic [CB_W-1:0] cmd_busy
);

    localparam int CW = $clog2(CLK_DIV + 1);
    localparam logic [CW-1:0] C_LAST = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] C_HALF = CW'(CLK_DIV / 2);
    localparam logic [CW-1:0] C_SMP  = CW'(SETTLE);

    typedef struct packed {
        phase_e          st;
        logic [CW-1:0]   cnt;
        logic [7:0]      sh;
        logic [3:0]      bidx;
        logic            ackm;
        logic            ackv;
        logic            sda_lo;
        logic            scl_lo;
        logic            buf_full;
        logic            coll;
        logic            evt;
        logic [CB_W-1:0] cmd;
    } eng_t;

    eng_t q, d;
    logic last, bitval, chk_en, smp_now, coll_now, done;

    always_comb begin
        d      = q;
        last   = (q.cnt == C_LAST);
        done   = 1'b0;
        bitval = q.ackm ? q.ackv : ((q.bidx < 4'd8) ? q.sh[7] : 1'b1);
        chk_en = 1'b0;
        d.cnt  = last ? '0 : q.cnt + 1'b1;

        if (coll_clr) d.coll = 1'b0;
        if (evt_clr)  d.evt  = 1'b0;

        if (wr_stb && !q.buf_full) begin
            d.sh       = wr_data;
            d.bidx     = '0;
            d.buf_full = 1'b1;
        end

        case (q.st)
            PH_IDLE: begin
                d.cnt = '0;
                if (start_cmd && bus_free) begin
                    d.st          = PH_STA_A;
                    d.cmd[CB_STA] = 1'b1;
                end
            end
            PH_HOLD: begin
                d.cnt = '0;
                if (rstart_cmd) begin
                    d.st           = PH_RS_PRE;
                    d.cmd[CB_RSTA] = 1'b1;
                end else if (stop_cmd) begin
                    d.st          = PH_STP_A;
                    d.cmd[CB_STP] = 1'b1;
                end else if (ack_cmd) begin
                    d.st          = PH_BIT_LO;
                    d.ackm        = 1'b1;
                    d.ackv        = ack_val;
                    d.cmd[CB_ACK] = 1'b1;
                end else if (q.buf_full) begin
                    d.st   = PH_BIT_LO;
                    d.ackm = 1'b0;
                end
            end
            PH_RS_PRE: begin
                if (q.cnt == C_HALF) d.sda_lo = 1'b0;
                if (last) begin
                    d.st     = PH_STA_A;
                    d.scl_lo = 1'b0;
                end
            end
            PH_STA_A: begin
                chk_en = 1'b1;
                if (last) begin
                    d.st     = PH_STA_B;
                    d.sda_lo = 1'b1;
                end
            end
            PH_STA_B: begin
                if (last) begin
                    d.st     = PH_HOLD;
                    d.scl_lo = 1'b1;
                    d.cmd    = '0;
                    done     = 1'b1;
                end
            end
            PH_BIT_LO: begin
                if (q.cnt == C_HALF) d.sda_lo = ~bitval;
                if (last) begin
                    d.st     = PH_BIT_HI;
                    d.scl_lo = 1'b0;
                end
            end
            PH_BIT_HI: begin
                chk_en = q.ackm | (q.bidx < 4'd8);
                if (last) begin
                    d.scl_lo = 1'b1;
                    if (q.ackm) begin
                        d.st   = PH_HOLD;
                        d.ackm = 1'b0;
                        d.cmd  = '0;
                        done   = 1'b1;
                    end else if (q.bidx == 4'd8) begin
                        d.st       = PH_HOLD;
                        d.buf_full = 1'b0;
                        done       = 1'b1;
                    end else begin
                        d.st   = PH_BIT_LO;
                        d.bidx = q.bidx + 1'b1;
                        d.sh   = {q.sh[6:0], 1'b0};
                    end
                end
            end
            PH_STP_A: begin
                if (q.cnt == C_HALF) d.sda_lo = 1'b1;
                if (last) begin
                    d.st     = PH_STP_B;
                    d.scl_lo = 1'b0;
                end
            end
            PH_STP_B: begin
                if (last) begin
                    d.st     = PH_STP_C;
                    d.sda_lo = 1'b0;
                end
            end
            PH_STP_C: begin
                chk_en = 1'b1;
                if (last) begin
                    d.st  = PH_IDLE;
                    d.cmd = '0;
                    done  = 1'b1;
                end
            end
            default: d.st = PH_IDLE;
        endcase

        smp_now  = (q.cnt == C_SMP) && chk_en;
        coll_now = (smp_now && !q.sda_lo && scl_s && !sda_s)
                 || (q.st == PH_IDLE && start_cmd && !bus_free);

        if (done || stop_det) d.evt = 1'b1;

        if (coll_now) begin
            d.st       = PH_IDLE;
            d.cnt      = '0;
            d.sda_lo   = 1'b0;
            d.scl_lo   = 1'b0;
            d.buf_full = 1'b0;
            d.cmd      = '0;
            d.ackm     = 1'b0;
            d.bidx     = '0;
            d.coll     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: PH_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_lo    = q.sda_lo;
    assign scl_lo    = q.scl_lo;
    assign buf_full  = q.buf_full;
    assign coll_flag = q.coll;
    assign evt_flag  = q.evt;
    assign cmd_busy  = q.cmd;

    // R3
    sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == PH_BIT_LO || q.st == PH_BIT_HI) && q.sda_lo != $past(q.sda_lo))
        |-> (q.scl_lo && $past(q.scl_lo)));

    // R6
    coll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coll_now |=> (!q.sda_lo && !q.scl_lo && !q.buf_full && q.cmd == '0 && q.coll));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_IDLE && start_cmd && !bus_free)
        |=> (q.coll && q.st == PH_IDLE && !q.scl_lo && !q.sda_lo));

    // R8
    coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.coll && !coll_clr) |=> q.coll);

endmodule

// File: rtl/i2c_arb_tx.sv
module i2c_arb_tx
    import i2c_arb_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int SETTLE  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       start_cmd,
    input  logic       rstart_cmd,
    input  logic       stop_cmd,
    input  logic       ack_cmd,
    input  logic       ack_val,
    input  logic       coll_clr,
    input  logic       evt_clr,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_lo,
    output logic       scl_lo,
    output logic       buf_full,
    output logic       coll_flag,
    output logic       evt_flag,
    output logic [3:0] cmd_busy,
    output logic       start_seen,
    output logic       stop_seen
);

    logic scl_s, sda_s, stop_det, bus_free;

    i2c_arb_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .stop_det   (stop_det),
        .bus_free   (bus_free),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    i2c_arb_fsm #(.CLK_DIV(CLK_DIV), .SETTLE(SETTLE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .start_cmd  (start_cmd),
        .rstart_cmd (rstart_cmd),
        .stop_cmd   (stop_cmd),
        .ack_cmd    (ack_cmd),
        .ack_val    (ack_val),
        .coll_clr   (coll_clr),
        .evt_clr    (evt_clr),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .bus_free   (bus_free),
        .stop_det   (stop_det),
        .sda_lo     (sda_lo),
        .scl_lo     (scl_lo),
        .buf_full   (buf_full),
        .coll_flag  (coll_flag),
        .evt_flag   (evt_flag),
        .cmd_busy   (cmd_busy)
    );

endmodule

// File: tb/tb_i2c_arb_tx.sv
module tb_i2c_arb_tx;

    localparam int TCLK = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0, start_cmd = 1'b0, rstart_cmd = 1'b0, stop_cmd = 1'b0;
    logic ack_cmd = 1'b0, ack_val = 1'b0, coll_clr = 1'b0, evt_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic oth_sda = 1'b0, oth_scl = 1'b0;
    logic scl_line, sda_line;
    logic sda_lo, scl_lo, buf_full, coll_flag, evt_flag, start_seen, stop_seen;
    logic [3:0] cmd_busy;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int         nb;
        logic [8:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #(TCLK/2) clk = ~clk;

    assign scl_line = ~(scl_lo | oth_scl);
    assign sda_line = ~(sda_lo | oth_sda);

    i2c_arb_tx dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .start_cmd(start_cmd), .rstart_cmd(rstart_cmd), .stop_cmd(stop_cmd),
        .ack_cmd(ack_cmd), .ack_val(ack_val), .coll_clr(coll_clr), .evt_clr(evt_clr),
        .scl_in(scl_line), .sda_in(sda_line), .sda_lo(sda_lo), .scl_lo(scl_lo),
        .buf_full(buf_full), .coll_flag(coll_flag), .evt_flag(evt_flag),
        .cmd_busy(cmd_busy), .start_seen(start_seen), .stop_seen(stop_seen)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // scoreboard monitor: collects bits at SCL rising edges of the line
    logic scl_pv = 1'b1, sda_pv = 1'b1;
    int m_cnt = 0;
    logic [8:0] m_sh = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line && scl_pv && sda_pv && !sda_line) begin
                m_cnt = 0;
                m_sh  = '0;
            end else if (scl_line && !scl_pv && exp_q.size() > 0) begin
                m_sh = {m_sh[7:0], sda_line};
                m_cnt++;
                if (m_cnt == exp_q[0].nb) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, {23'd0, m_sh}, {23'd0, e.v});
                    m_cnt = 0;
                    m_sh  = '0;
                end
            end
        end
        scl_pv = scl_line;
        sda_pv = sda_line;
    end

    task automatic wait_cmd_done();
        while (cmd_busy != 4'b0000) @(negedge clk);
    endtask

    task automatic scl_edges(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            logic p;
            p = scl_line;
            @(negedge clk);
            while (!(scl_line == lvl && p != lvl)) begin
                p = scl_line;
                @(negedge clk);
            end
        end
    endtask

    task automatic do_start();
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        chk("R2 start busy bit", {28'd0, cmd_busy}, 32'h1);
        wait_cmd_done();
        chk("R2 scl held", {31'd0, scl_lo}, 32'h1);
        chk("R2 sda held", {31'd0, sda_lo}, 32'h1);
        chk("R2 start seen", {31'd0, start_seen}, 32'h1);
        chk("R12 evt after start", {31'd0, evt_flag}, 32'h1);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    task automatic load_byte(input logic [7:0] b);
        wr_data = b;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk("R3 buf_full set", {31'd0, buf_full}, 32'h1);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        exp_q.push_back('{nb: 9, v: {b, 1'b1}, tag: tag});
        load_byte(b);
        while (buf_full) @(negedge clk);
    endtask

    task automatic do_stop();
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
        chk("R4 stop busy bit", {28'd0, cmd_busy}, 32'h4);
        wait_cmd_done();
        chk("R4 sda released", {31'd0, sda_lo}, 32'h0);
        chk("R4 scl released", {31'd0, scl_lo}, 32'h0);
        chk("R9 stop seen", {30'd0, stop_seen, start_seen}, 32'h2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 lines", {30'd0, sda_lo, scl_lo}, 32'h0);
        chk("R1 flags", {29'd0, buf_full, coll_flag, evt_flag}, 32'h0);
        chk("R1 status", {26'd0, cmd_busy, start_seen, stop_seen}, 32'h0);

        do_start();
        send_byte(8'hA5, "R3 byte A5");
        send_byte(8'h3C, "R3 byte 3C");

        // R4 acknowledge bit
        exp_q.push_back('{nb: 1, v: 9'd0, tag: "R4 ack bit"});
        ack_val = 1'b0;
        ack_cmd = 1'b1;
        @(negedge clk);
        ack_cmd = 1'b0;
        chk("R4 ack busy bit", {28'd0, cmd_busy}, 32'h8);
        wait_cmd_done();

        // R4 repeated start
        rstart_cmd = 1'b1;
        @(negedge clk);
        rstart_cmd = 1'b0;
        chk("R4 rstart busy bit", {28'd0, cmd_busy}, 32'h2);
        wait_cmd_done();
        chk("R4 rstart start seen", {31'd0, start_seen}, 32'h1);
        send_byte(8'h5A, "R3 byte 5A");
        do_stop();

        // R5 / R6 collision in the middle of a byte
        do_start();
        load_byte(8'hFF);
        scl_edges(3, 1'b1);
        scl_edges(1, 1'b0);
        oth_sda = 1'b1;
        while (!coll_flag) @(negedge clk);
        chk("R5 coll set", {31'd0, coll_flag}, 32'h1);
        chk("R6 buf_full cleared", {31'd0, buf_full}, 32'h0);
        chk("R6 lines released", {30'd0, sda_lo, scl_lo}, 32'h0);
        chk("R6 busy clear", {28'd0, cmd_busy}, 32'h0);

        // R8 sticky and clear
        repeat (20) @(negedge clk);
        chk("R8 coll sticky", {31'd0, coll_flag}, 32'h1);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        chk("R8 coll cleared", {31'd0, coll_flag}, 32'h0);

        // R10 start on busy bus
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        chk("R10 busy start coll", {31'd0, coll_flag}, 32'h1);
        chk("R10 no drive", {30'd0, sda_lo, scl_lo}, 32'h0);
        chk("R10 no busy bit", {28'd0, cmd_busy}, 32'h0);

        // R8 set wins over clear in the same cycle
        start_cmd = 1'b1;
        coll_clr  = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        coll_clr  = 1'b0;
        chk("R8 set wins", {31'd0, coll_flag}, 32'h1);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;

        // R12 clear, R9 stop from the other master
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        chk("R12 evt cleared", {31'd0, evt_flag}, 32'h0);
        oth_sda = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 foreign stop", {30'd0, stop_seen, start_seen}, 32'h2);
        chk("R9 evt on stop", {31'd0, evt_flag}, 32'h1);

        // R11 restart from MSB after collision
        exp_q.push_back('{nb: 9, v: {8'h81, 1'b1}, tag: "R11 byte 81"});
        load_byte(8'h81);
        do_start();
        while (buf_full) @(negedge clk);

        // R7 collision inside stop
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
        while (!(cmd_busy == 4'b0100 && scl_lo == 1'b0)) @(negedge clk);
        oth_sda = 1'b1;
        while (!coll_flag) @(negedge clk);
        chk("R7 stop aborted", {28'd0, cmd_busy}, 32'h0);
        chk("R7 stop lines", {30'd0, sda_lo, scl_lo}, 32'h0);
        oth_sda = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 stop after abort", {30'd0, stop_seen, start_seen}, 32'h2);

        // R7 collision inside start
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        oth_sda = 1'b1;
        while (!coll_flag) @(negedge clk);
        chk("R7 start aborted", {28'd0, cmd_busy}, 32'h0);
        chk("R9 foreign start", {30'd0, stop_seen, start_seen}, 32'h1);
        oth_sda = 1'b0;
        repeat (5) @(negedge clk);

        chk("R3 scoreboard drained", exp_q.size(), 32'h0);
        finish_run();
    end

endmodule